// File: doc/BRIEF.md
# GPIO Debounce Filter Bank

This block cleans up eight raw GPIO inputs before they reach logic that must not see contact bounce or short noise pulses. Each input first passes through a two-flop synchroniser. A per-pin stability counter then lets the clean output take a new level only once the synchronised input has disagreed with it, without a break, for a whole selected interval. A free-running prescaler turns the system clock, whose frequency is a parameter, into a one-microsecond tick that all counters share.

Software selects the interval through one 32-bit configuration word made of eight 4-bit fields, one per pin. Each field pairs a 3-bit period code with its own write-enable bit, so one write can retune any subset of pins and leave the rest alone. A build-time option selects a second code layout in which every stored code is one higher than the standard one.

Top module: `gpio_debounce_bank`

## Requirements
- R1: With the standard layout, period codes 0 to 6 select 1, 10, 100, 1000, 10000, 20000 and 30000 microsecond ticks. Let D be clock cycles per tick and P the tick count. After the raw input changes and then holds, the clean output follows no sooner than 3+D*(P-1) and no later than 2+D*P clock cycles later.
- R2: Pin n owns bits [4n+3:4n] of the configuration word. Bits [4n+2:4n] hold its code and bit 4n+3 is its write enable. When the write strobe is high and the enable bit is 1, a valid code is stored and shows on the read port after the next clock edge.
- R3: A field whose enable bit is 0 in a write keeps its stored code, whatever its code bits hold.
- R4: On the read port every enable bit position (4n+3) reads 0, and the code bits show the stored code.
- R5: With the standard layout, code 7 is reserved. A write that carries it with the enable set leaves that field unchanged.
- R6: A raw pulse shorter than the selected interval never reaches the clean output, even when pulses repeat. Each return of the raw input to the clean level restarts the count, so a later change still needs the full interval.
- R7: Reset loads code 0 (1 us) into every field. Within 5 clock edges after reset is released, each clean output equals the raw level held through reset, with no debounce wait.
- R8: An accepted write to a pin's field clears that pin's stability counter. The new interval is counted from the next tick, so a change that has been pending under a long interval and is switched to 1 us shows within 2 to D+1 cycles of the write.
- R9: With the offset layout, stored values 1 to 7 mean the standard codes 0 to 6, stored value 0 is reserved and ignored, and reset stores 1 in every field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal synchroniser |
| cfg_we | input | 1 | Configuration write strobe, one cycle per write |
| cfg_wdata | input | 4*NUM_PINS | Write word: per pin a 3-bit code and one enable bit |
| cfg_rdata | output | 4*NUM_PINS | Stored codes, enable positions reading 0 |
| pin_raw | input | NUM_PINS | Raw asynchronous pin levels |
| pin_clean | output | NUM_PINS | Debounced pin levels |

## Verification
A configuration write takes effect at the clock edge that samples the strobe, so the bench reads the field back at the falling edge after that edge. A debounced change is due 3+D*(P-1) to 2+D*P cycles after the raw change: two synchroniser stages, then P ticks whose phase against the change is unknown. The bench therefore counts whole cycles from the falling edge where it drives the input and checks the count against that window rather than against one exact cycle. The restart case is timed from the write instead, with a window of 2 to D+1 cycles. The post-reset level is checked after the synchroniser and the priming stage have filled.

// File: rtl/gpio_dbn_pkg.sv
package gpio_dbn_pkg;

  localparam int CODE_W    = 3;
  localparam int FIELD_W   = 4;
  localparam int TICKS_MAX = 30000;
  localparam int CNT_W     = $clog2(TICKS_MAX + 1);

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [CNT_W-1:0]  ticks_t;

  // Standard code (0..6) to number of microsecond ticks.
  function automatic ticks_t code_to_ticks(input code_t idx);
    ticks_t t;
    case (idx)
      3'd0:    t = ticks_t'(1);
      3'd1:    t = ticks_t'(10);
      3'd2:    t = ticks_t'(100);
      3'd3:    t = ticks_t'(1000);
      3'd4:    t = ticks_t'(10000);
      3'd5:    t = ticks_t'(20000);
      3'd6:    t = ticks_t'(30000);
      default: t = ticks_t'(1);
    endcase
    return t;
  endfunction

  // A stored code is legal unless it is the reserved value of the layout.
  function automatic logic code_ok(input code_t c, input logic biased);
    return biased ? (c != 3'd0) : (c != 3'd7);
  endfunction

endpackage

// File: rtl/gpio_dbn_tick.sv
module gpio_dbn_tick #(
  parameter int DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  generate
    if (DIV <= 1) begin : g_every
      logic unused_ok;
      assign unused_ok = clk ^ rst_n;
      assign tick = 1'b1;
    end else begin : g_count
      localparam int W = $clog2(DIV);
      logic [W-1:0] cnt_q, cnt_d;

      assign tick = (cnt_q == W'(DIV - 1));

      always_comb begin
        cnt_d = tick ? '0 : cnt_q + W'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end
    end
  endgenerate

endmodule

// File: rtl/gpio_dbn_cfg.sv
module gpio_dbn_cfg
  import gpio_dbn_pkg::*;
#(
  parameter int NUM_PINS  = 8,
  parameter bit CODE_BIAS = 1'b0,
  localparam int REG_W    = NUM_PINS * FIELD_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we,
  input  logic [REG_W-1:0]                 wdata,
  output logic [REG_W-1:0]                 rdata,
  output logic [NUM_PINS-1:0][CODE_W-1:0]  code_o,
  output logic [NUM_PINS-1:0]              restart_o
);

  generate
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_field
      code_t field_q, field_d, cand;
      logic  take;

      assign cand = wdata[g*FIELD_W +: CODE_W];
      assign take = we & wdata[g*FIELD_W + CODE_W] & code_ok(cand, CODE_BIAS);

      always_comb begin
        field_d = take ? cand : field_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) field_q <= CODE_W'(CODE_BIAS);
        else        field_q <= field_d;
      end

      assign code_o[g]                    = field_q;
      assign restart_o[g]                 = take;
      assign rdata[g*FIELD_W +: FIELD_W]  = {1'b0, field_q};
    end
  endgenerate

endmodule

// File: rtl/gpio_dbn_pin.sv
module gpio_dbn_pin
  import gpio_dbn_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   raw,
  input  logic   tick,
  input  logic   prime,
  input  logic   restart,
  input  ticks_t period,
  output logic   clean
);

  logic   s1_q, s2_q;
  logic   filt_q, filt_d;
  ticks_t cnt_q, cnt_d;

  always_comb begin
    filt_d = filt_q;
    cnt_d  = cnt_q;
    if (prime) begin
      filt_d = s2_q;
      cnt_d  = '0;
    end else if (restart || (s2_q == filt_q)) begin
      cnt_d  = '0;
    end else if (tick) begin
      if (cnt_q == period - ticks_t'(1)) begin
        filt_d = s2_q;
        cnt_d  = '0;
      end else begin
        cnt_d  = cnt_q + ticks_t'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      s1_q   <= raw;
      s2_q   <= s1_q;
      filt_q <= filt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign clean = filt_q;

endmodule

// File: rtl/gpio_debounce_bank.sv
module gpio_debounce_bank
  import gpio_dbn_pkg::*;
#(
  parameter int CLK_HZ    = 100_000_000,
  parameter int NUM_PINS  = 8,
  parameter bit CODE_BIAS = 1'b0,
  localparam int REG_W    = NUM_PINS * FIELD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [REG_W-1:0]    cfg_wdata,
  output logic [REG_W-1:0]    cfg_rdata,
  input  logic [NUM_PINS-1:0] pin_raw,
  output logic [NUM_PINS-1:0] pin_clean
);

  localparam int DIV = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_pipe_q;
  logic       sys_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign sys_rst_n = rst_pipe_q[1];

  // Priming: the clean outputs copy the synchroniser until it has filled.
  logic [2:0] prime_q, prime_d;
  logic       prime;

  always_comb begin
    prime_d = {prime_q[1:0], 1'b1};
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) prime_q <= '0;
    else            prime_q <= prime_d;
  end
  assign prime = ~prime_q[2];

  logic                            tick;
  logic [NUM_PINS-1:0][CODE_W-1:0] code;
  logic [NUM_PINS-1:0]             restart;

  gpio_dbn_tick #(.DIV(DIV)) u_tick (
    .clk   (clk),
    .rst_n (sys_rst_n),
    .tick  (tick)
  );

  gpio_dbn_cfg #(.NUM_PINS(NUM_PINS), .CODE_BIAS(CODE_BIAS)) u_cfg (
    .clk       (clk),
    .rst_n     (sys_rst_n),
    .we        (cfg_we),
    .wdata     (cfg_wdata),
    .rdata     (cfg_rdata),
    .code_o    (code),
    .restart_o (restart)
  );

  generate
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      code_t  idx;
      ticks_t period;

      assign idx    = code[p] - CODE_W'(CODE_BIAS);
      assign period = code_to_ticks(idx);

      gpio_dbn_pin u_pin (
        .clk     (clk),
        .rst_n   (sys_rst_n),
        .raw     (pin_raw[p]),
        .tick    (tick),
        .prime   (prime),
        .restart (restart[p]),
        .period  (period),
        .clean   (pin_clean[p])
      );
    end
  endgenerate

endmodule

// File: rtl/gpio_debounce_bank_chk.sv
module gpio_debounce_bank_chk #(
  parameter int NUM_PINS  = 8,
  parameter bit CODE_BIAS = 1'b0,
  localparam int REG_W    = NUM_PINS * 4
) (
  input logic                clk,
  input logic                sys_rst_n,
  input logic                cfg_we,
  input logic [REG_W-1:0]    cfg_wdata,
  input logic [REG_W-1:0]    cfg_rdata,
  input logic [NUM_PINS-1:0] pin_raw,
  input logic [NUM_PINS-1:0] pin_clean
);

  localparam logic [2:0] RSV = CODE_BIAS ? 3'd0 : 3'd7;

  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
      // R2: an enabled write of a legal code lands in its field
      a_r2_write_lands: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (cfg_we && cfg_wdata[4*i+3] && (cfg_wdata[4*i +: 3] != RSV))
        |=> (cfg_rdata[4*i +: 3] == $past(cfg_wdata[4*i +: 3])));

      // R3: a field with its enable clear is left alone
      a_r3_masked_keep: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (cfg_we && !cfg_wdata[4*i+3]) |=> $stable(cfg_rdata[4*i +: 4]));

      // R5: a reserved code is dropped
      a_r5_reserved_keep: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (cfg_we && cfg_wdata[4*i+3] && (cfg_wdata[4*i +: 3] == RSV))
        |=> $stable(cfg_rdata[4*i +: 4]));

      // R1: a clean change always takes the level the synchroniser delivered
      a_r1_clean_follows_sync: assert property (@(posedge clk) disable iff (!sys_rst_n)
        !$stable(pin_clean[i]) |-> (pin_clean[i] == $past(pin_raw[i], 3)));
    end
  endgenerate

endmodule

bind gpio_debounce_bank gpio_debounce_bank_chk #(
  .NUM_PINS  (NUM_PINS),
  .CODE_BIAS (CODE_BIAS)
) u_chk (
  .clk       (clk),
  .sys_rst_n (sys_rst_n),
  .cfg_we    (cfg_we),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .pin_raw   (pin_raw),
  .pin_clean (pin_clean)
);

// File: tb/gpio_debounce_bank_test.sv
`timescale 1ns/1ps
module gpio_debounce_bank_test;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 2_000_000;
  localparam int D          = CLK_HZ / 1_000_000;
  localparam int WD_LIMIT   = 190_000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        we_a, we_b;
  logic [31:0] wd_a, wd_b, rd_a, rd_b;
  logic [7:0]  raw, cl_a, cl_b;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_debounce_bank #(.CLK_HZ(CLK_HZ), .NUM_PINS(8), .CODE_BIAS(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(we_a), .cfg_wdata(wd_a),
    .cfg_rdata(rd_a), .pin_raw(raw), .pin_clean(cl_a));

  gpio_debounce_bank #(.CLK_HZ(CLK_HZ), .NUM_PINS(8), .CODE_BIAS(1'b1)) uut_b (
    .clk(clk), .rst_n(rst_n), .cfg_we(we_b), .cfg_wdata(wd_b),
    .cfg_rdata(rd_b), .pin_raw(raw), .pin_clean(cl_b));

  function automatic int ticks_of(input int c);
    case (c)
      0: return 1;     1: return 10;    2: return 100;   3: return 1000;
      4: return 10000; 5: return 20000; default: return 30000;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_range(input string tag, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic cfg_write(input bit sel, input logic [31:0] data);
    @(negedge clk);
    if (sel) begin we_b = 1'b1; wd_b = data; end
    else     begin we_a = 1'b1; wd_a = data; end
    @(negedge clk);
    we_a = 1'b0; we_b = 1'b0;
  endtask

  // Flip one raw pin and count edges until the chosen clean output follows.
  task automatic measure(input bit sel, input int pin, output int m);
    @(negedge clk);
    raw[pin] = ~raw[pin];
    m = 0;
    for (int k = 0; k < 80000; k++) begin
      @(posedge clk);
      m++;
      @(negedge clk);
      if ((sel ? cl_b[pin] : cl_a[pin]) == raw[pin]) break;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; we_a = 1'b0; we_b = 1'b0; wd_a = '0; wd_b = '0; raw = 8'hA5;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R7 clean after reset", {24'd0, cl_a}, 32'h0000_00A5);
    check("R7 codes after reset", rd_a, 32'h0000_0000);
    check("R9 offset codes after reset", rd_b, 32'h1111_1111);
  endtask

  task automatic t_fields();
    cfg_write(1'b0, 32'h8EDC_BA98);
    check("R2 all fields written", rd_a, 32'h0654_3210);
    check("R4 enable bits read zero", rd_a & 32'h8888_8888, 32'h0);
    cfg_write(1'b0, 32'h5595_5E55);
    check("R3 masked write", rd_a, 32'h0614_3610);
    cfg_write(1'b0, 32'h0000_00F0);
    check("R5 reserved code ignored", rd_a, 32'h0614_3610);
    cfg_write(1'b0, 32'h0000_0F0A);
    check("R5 reserved beside legal", rd_a, 32'h0614_3612);
  endtask

  task automatic t_periods();
    int codes [5] = '{0, 1, 2, 3, 6};
    for (int j = 0; j < 5; j++) begin
      int m, p;
      cfg_write(1'b0, 32'(4'h8 | codes[j]) << (4 * j));
      repeat (3) @(negedge clk);
      p = ticks_of(codes[j]);
      measure(1'b0, j, m);
      check_range($sformatf("R1 code %0d delay", codes[j]), m, 3 + D*(p-1), 2 + D*p);
    end
  endtask

  task automatic t_glitch();
    logic lvl;
    int   m;
    cfg_write(1'b0, 32'h0090_0000);
    repeat (30) @(negedge clk);
    lvl = cl_a[5];
    for (int k = 0; k < 3; k++) begin
      raw[5] = ~lvl;
      repeat (12) @(negedge clk);
      raw[5] = lvl;
      repeat (4) @(negedge clk);
    end
    repeat (60) @(negedge clk);
    check("R6 short pulses rejected", {31'd0, cl_a[5]}, {31'd0, lvl});
    measure(1'b0, 5, m);
    check_range("R6 full interval after glitches", m, 3 + D*9, 2 + D*10);
  endtask

  task automatic t_restart();
    int m;
    logic lvl;
    cfg_write(1'b0, 32'h0B00_0000);
    repeat (5) @(negedge clk);
    lvl = cl_a[6];
    raw[6] = ~lvl;
    repeat (1500) @(negedge clk);
    check("R8 still pending under long interval", {31'd0, cl_a[6]}, {31'd0, lvl});
    we_a = 1'b1; wd_a = 32'h0800_0000;
    m = 0;
    for (int k = 0; k < 5000; k++) begin
      @(posedge clk);
      m++;
      @(negedge clk);
      we_a = 1'b0;
      if (cl_a[6] == raw[6]) break;
    end
    check_range("R8 restart with short interval", m, 2, D + 1);
  endtask

  task automatic t_bias();
    int m;
    cfg_write(1'b1, 32'h0000_000A);
    check("R9 offset code stored", rd_b, 32'h1111_1112);
    cfg_write(1'b1, 32'h0000_0008);
    check("R9 offset reserved ignored", rd_b, 32'h1111_1112);
    repeat (30) @(negedge clk);
    measure(1'b1, 0, m);
    check_range("R9 offset code 2 means 10 us", m, 3 + D*9, 2 + D*10);
  endtask

  initial begin
    t_reset();
    t_fields();
    t_periods();
    t_glitch();
    t_restart();
    t_bias();
    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    for (int c = 0; c < WD_LIMIT; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish within %0d cycles", WD_LIMIT);
      report();
      $finish;
    end
  end

endmodule